// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects interrupt events from eight DMA channels and turns them into one host interrupt. Each channel owns a sticky pending bit. A one-cycle event pulse sets the bit, and software clears it by writing a one to that channel's status location. A per-channel enable input decides whether the pending bit takes part in interrupt generation. The pending bit is recorded even while the channel is disabled, so enabling the channel later still delivers the interrupt.

A mode input selects how the interrupt reaches the host. In legacy mode a level line stays high while any enabled channel is pending. In message mode all channels share a single vector. A send request goes up when an enabled channel's pending state becomes active. The request then stays up until the message interface acknowledges it, and further activations that arrive in the meantime merge into it.

Each channel is one coalesced source, so an event on a channel that is already pending causes no new interrupt. A summary output and a read port at address 0 show which channels are pending. Software can then read the per-channel status at address 1 + channel.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset no channel is pending, `inta_o` is low, `msi_req_o` is low, and reads of address 0 return 0.
- R2: An `ev_i[k]` pulse sampled at a clock edge sets pending bit k at that edge, whether or not the channel is enabled. `pend_o` and a read of address 0 show bit k set from then on.
- R3: A write to address k+1 with `wdata_i[0]`=1 clears pending bit k. A write with `wdata_i[0]`=0, or a write to any other address, leaves bit k unchanged.
- R4: When an event and a clear for the same channel happen in the same cycle, the pending bit ends up set.
- R5: With `msi_mode_i`=0, `inta_o` equals the OR over all channels of pending AND `en_i`, with no delay from those signals.
- R6: With `msi_mode_i`=1, `inta_o` is low.
- R7: An event on a channel that is already pending and enabled raises no new message request and changes no state.
- R8: In message mode, when the vector of pending AND `en_i` gains a set bit, `msi_req_o` is high from the next clock edge. It stays high until a cycle with `msi_ack_i`=1, and it drops after that edge unless a new activation happens in the same cycle. Activations that arrive while the request is up produce no second request.
- R9: A pending but disabled channel drives neither output. Setting its enable later raises `inta_o` at once in legacy mode, or a request at the next edge in message mode.
- R10: The read port is combinational. Address 0 returns the pending vector, address k+1 returns pending bit k in bit 0 with the other bits 0, and every other address returns 0.
- R11: With `msi_mode_i`=0, `msi_req_o` is low, any outstanding request is discarded, and activations queue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_i | input | N_CH | Per-channel event pulses |
| en_i | input | N_CH | Per-channel interrupt enables |
| msi_mode_i | input | 1 | 0 selects the legacy level line, 1 selects single-vector messages |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address (0 is the summary, k+1 is channel k) |
| wdata_i | input | N_CH | Write data; bit 0 = 1 clears the addressed channel |
| rdata_o | output | N_CH | Combinational read data for `addr_i` |
| pend_o | output | N_CH | Summary of pending channels |
| inta_o | output | 1 | Legacy level interrupt |
| msi_req_o | output | 1 | Message send request |
| msi_ack_i | input | 1 | Message interface accepts the request |

## Verification
The bench targets the cases where a pending bit sees an event and a clear in the same cycle. A design that lets the clear win loses an interrupt there. It also targets an event on an already pending channel: a design that detects events instead of pending transitions would send a duplicate message. Requests are held without an acknowledge and extra activations arrive during the hold, which exposes a request that drops early or one that queues a second message. A disabled channel is enabled late, and the mode is switched while a request is outstanding. A long pseudo-random sweep over events, enables, writes, addresses and acknowledges compares every output against an arithmetic model each cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DEF_N_CH = 8;

  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_MSG    = 1'b1
  } irq_mode_e;

  function automatic int unsigned addr_width(input int unsigned n_ch);
    return (n_ch < 2) ? 1 : $clog2(n_ch + 1);
  endfunction
endpackage

// File: rtl/dma_irq_pend_cell.sv
module dma_irq_pend_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  input  logic en_i,
  output logic pend_o,
  output logic active_o
);
  logic pend_q;

  // event has priority over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (ev_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o   = pend_q;
  assign active_o = pend_q & en_i;
endmodule

// File: rtl/dma_irq_msg_gen.sv
module dma_irq_msg_gen #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] active_i,
  input  dma_irq_pkg::irq_mode_e mode_i,
  input  logic            ack_i,
  output logic            req_o
);
  import dma_irq_pkg::*;

  logic [N_CH-1:0] active_q;
  logic            req_q;
  logic            req_d;
  logic            rise;

  assign rise = |(active_i & ~active_q);

  always_comb begin
    req_d = 1'b0;
    if (mode_i == MODE_MSG) req_d = (req_q & ~ack_i) | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      req_q    <= 1'b0;
    end else begin
      active_q <= active_i;
      req_q    <= req_d;
    end
  end

  assign req_o = req_q & (mode_i == MODE_MSG);
endmodule

// File: rtl/dma_irq_rd_mux.sv
module dma_irq_rd_mux #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned AW   = 4
) (
  input  logic [N_CH-1:0] pend_i,
  input  logic [AW-1:0]   addr_i,
  output logic [N_CH-1:0] rdata_o
);
  logic [N_CH-1:0] sel;

  for (genvar k = 0; k < N_CH; k++) begin : g_sel
    localparam logic [AW-1:0] CH_ADDR = AW'(k + 1);
    assign sel[k] = (addr_i == CH_ADDR);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = pend_i;
    else rdata_o[0] = |(sel & pend_i);
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int unsigned N_CH = dma_irq_pkg::DEF_N_CH,
  parameter int unsigned AW   = dma_irq_pkg::addr_width(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] ev_i,
  input  logic [N_CH-1:0] en_i,
  input  logic            msi_mode_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] rdata_o,
  output logic [N_CH-1:0] pend_o,
  output logic            inta_o,
  output logic            msi_req_o,
  input  logic            msi_ack_i
);
  import dma_irq_pkg::*;

  irq_mode_e       mode;
  logic [N_CH-1:0] clr;
  logic [N_CH-1:0] active;

  assign mode = msi_mode_i ? MODE_MSG : MODE_LEGACY;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam logic [AW-1:0] CH_ADDR = AW'(k + 1);
    assign clr[k] = wr_en_i & (addr_i == CH_ADDR) & wdata_i[0];

    dma_irq_pend_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ev_i    (ev_i[k]),
      .clr_i   (clr[k]),
      .en_i    (en_i[k]),
      .pend_o  (pend_o[k]),
      .active_o(active[k])
    );
  end

  assign inta_o = (mode == MODE_LEGACY) & (|active);

  dma_irq_msg_gen #(.N_CH(N_CH)) u_msg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .mode_i  (mode),
    .ack_i   (msi_ack_i),
    .req_o   (msi_req_o)
  );

  dma_irq_rd_mux #(.N_CH(N_CH), .AW(AW)) u_rd (
    .pend_i (pend_o),
    .addr_i (addr_i),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] ev_i,
  input logic [N_CH-1:0] en_i,
  input logic            msi_mode_i,
  input logic            wr_en_i,
  input logic            msi_ack_i,
  input logic [N_CH-1:0] pend_o,
  input logic            inta_o,
  input logic            msi_req_o
);
  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((pend_o & $past(ev_i)) == $past(ev_i))); // R2

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_o) & ~pend_o)) |-> $past(wr_en_i)); // R3

  AST_INTA_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> (|(pend_o & en_i))); // R5

  AST_NO_INTA_IN_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_mode_i |-> !inta_o); // R6

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_req_o && !msi_ack_i && msi_mode_i) ##1 msi_mode_i |-> msi_req_o); // R8

  AST_NO_REQ_IN_LEGACY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msi_mode_i |-> !msi_req_o); // R11
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ev_i      (ev_i),
  .en_i      (en_i),
  .msi_mode_i(msi_mode_i),
  .wr_en_i   (wr_en_i),
  .msi_ack_i (msi_ack_i),
  .pend_o    (pend_o),
  .inta_o    (inta_o),
  .msi_req_o (msi_req_o)
);

// File: tb/sim_dma_irq_agg.sv
module sim_dma_irq_agg;
  localparam int N  = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  ev, en, wdata, rdata, pend;
  logic          mode, wr, ack, inta, req;
  logic [AW-1:0] addr;

  dma_irq_agg #(.N_CH(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .en_i(en), .msi_mode_i(mode),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pend_o(pend), .inta_o(inta), .msi_req_o(req), .msi_ack_i(ack)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [N-1:0] m_pend = '0, m_act_q = '0;
  logic         m_req = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_rd(input logic [AW-1:0] a, input logic [N-1:0] p);
    if (a == 0) return p;
    if (a <= N) return {{(N-1){1'b0}}, p[a-1]};
    return '0;
  endfunction

  // drive one cycle, check pre-edge outputs, advance the model
  task automatic cyc(input logic [N-1:0] e, input logic [N-1:0] n, input logic md,
                     input logic w, input logic [AW-1:0] a, input logic [N-1:0] wd,
                     input logic k);
    logic [N-1:0] clr, act, pend_n;
    logic rise, req_n;
    @(negedge clk);
    ev = e; en = n; mode = md; wr = w; addr = a; wdata = wd; ack = k;
    #1;
    act = m_pend & n;
    chk("R5 R6 inta", inta, (!md) && (|act));
    chk("R8 R11 msi_req", req, m_req & md);
    chk("R10 rdata", rdata, exp_rd(a, m_pend));
    chk("R2 summary", pend, m_pend);
    clr = '0;
    if (w && a >= 1 && a <= N && wd[0]) clr[a-1] = 1'b1;
    pend_n = (m_pend & ~clr) | e;
    rise = |(act & ~m_act_q);
    req_n = md ? ((m_req & ~k) | rise) : 1'b0;
    @(posedge clk);
    m_pend = pend_n; m_act_q = act; m_req = req_n;
  endtask

  task automatic idle(input logic [N-1:0] n, input logic md);
    cyc('0, n, md, 1'b0, '0, '0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; ev = '0; en = '0; mode = 1'b0; wr = 1'b0; addr = '0; wdata = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pend", pend, 0); chk("R1 inta", inta, 0); chk("R1 req", req, 0); chk("R1 rdata", rdata, 0);

    // R2 / R9: event on disabled channel is latched, drives nothing
    cyc(8'h08, 8'h00, 0, 0, 0, 0, 0);
    idle(8'h00, 0);
    chk("R2 pend ch3", pend, 8'h08);
    chk("R9 disabled no inta", inta, 0);
    idle(8'h08, 0);
    chk("R9 late enable inta", inta, 1);

    // R3: write of 0 / wrong address ignored, W1C clears
    cyc('0, 8'h08, 0, 1, 4'd4, 8'h00, 0);
    cyc('0, 8'h08, 0, 1, 4'd5, 8'h01, 0);
    cyc('0, 8'h08, 0, 1, 4'd0, 8'hFF, 0);
    idle(8'h08, 0);
    chk("R3 not cleared", pend, 8'h08);
    cyc('0, 8'h08, 0, 1, 4'd4, 8'h01, 0);
    idle(8'h08, 0);
    chk("R3 cleared", pend, 8'h00);

    // R4: event and clear together
    cyc(8'h04, 8'h00, 0, 1, 4'd3, 8'h01, 0);
    idle(8'h00, 0);
    chk("R4 event wins", pend, 8'h04);
    cyc('0, 8'h00, 0, 1, 4'd3, 8'h01, 0);

    // R8 / R7 in message mode
    idle(8'hFF, 1);
    cyc(8'h01, 8'hFF, 1, 0, 0, 0, 0);
    idle(8'hFF, 1);
    idle(8'hFF, 1);
    chk("R8 req raised", req, 1);
    chk("R6 no inta", inta, 0);
    cyc(8'h02, 8'hFF, 1, 0, 0, 0, 0);
    repeat (3) idle(8'hFF, 1);
    chk("R8 held", req, 1);
    cyc('0, 8'hFF, 1, 0, 0, 0, 1);
    idle(8'hFF, 1);
    chk("R8 merged, dropped after ack", req, 0);
    cyc(8'h01, 8'hFF, 1, 0, 0, 0, 0);
    repeat (2) idle(8'hFF, 1);
    chk("R7 coalesced", req, 0);

    // R9 in message mode: pending ch5 disabled, enable later
    cyc(8'h20, 8'h03, 1, 0, 0, 0, 0);
    repeat (2) idle(8'h03, 1);
    chk("R9 masked no req", req, 0);
    idle(8'h23, 1);
    idle(8'h23, 1);
    chk("R9 late enable req", req, 1);

    // R11: switch to legacy drops request
    idle(8'h23, 0);
    chk("R11 req low", req, 0);
    chk("R11 inta", inta, 1);
    idle(8'h23, 1);
    chk("R11 discarded", req, 0);

    // near-exhaustive per-channel sweep: set, enable, clear
    for (int c = 0; c < N; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int e = 0; e < 2; e++) begin
          for (int k = 1; k <= N; k++) cyc('0, '0, m[0], 1, AW'(k), 8'h01, 0);
          cyc(N'(1) << c, e ? (N'(1) << c) : '0, m[0], 0, 0, 0, 0);
          repeat (2) idle(e ? (N'(1) << c) : '0, m[0]);
          cyc('0, '0, m[0], 0, AW'(c + 1), 0, 1);
        end
      end
    end

    // pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] e_r, n_r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e_r = (lfsr[7:0] & lfsr[15:8]) & {N{lfsr[3]}};
      n_r = lfsr[11:4] | lfsr[15:8];
      cyc(e_r, n_r, (i % 500) > 60, lfsr[2], AW'(lfsr[6:3] % 11), {7'b0, lfsr[9]}, lfsr[1] & lfsr[0]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule